// File: doc/BRIEF.md
# Circular Interrupt Event Queue

This block sorts the events reported by a message engine into two classes. A standard-priority event is written as a two-word packet into a ring of packet slots in shared memory. The first word holds the event code and the second word holds a pointer to the block that raised the event. A counter of unserviced packets drives the standard interrupt request. A high-priority event does not use the queue. It sets a status flag, which raises a separate interrupt request and stalls the message engine until the host clears the flag.

The host uses register writes to set the enables and the ring start address, to take serviced packets off the pending count, to clear that count, to clear high-priority flags, and to issue a master reset of the queue bookkeeping. Events arrive as single-cycle strobes. Each event carries a code in the range 0 to N_EVT-1 and a block pointer. The message engine spaces standard events at least three cycles apart.

Top module: `irq_event_queue`

## Requirements
- R1: After the asynchronous reset, the outputs are as follows: pending count 0, exceed flag 0, both interrupt requests 0, stall 0, no memory write, and ring pointer 0.
- R2: An event whose code has its high-priority enable set is never queued. Any other event is queued only when bit 0 (master) and bit code+1 of the standard enable register (select 0) are both set. Otherwise the event has no effect: nothing is written and the count does not change.
- R3: A queued event accepted at clock edge t writes memory in two cycles. In the cycle after t, the event code, zero-extended, goes to the current ring pointer. In the next cycle, the block pointer goes to the ring pointer plus 1.
- R4: A write to select 2 loads the ring start address and makes it the ring pointer. After each packet's second word, the pointer advances by 2. After 256 packets it returns to the start address.
- R5: Each queued event raises the pending count by 1 on the accepting edge. The standard interrupt request is high exactly while the count is nonzero.
- R6: A write to select 3 lowers the count by 1. It has no effect at 0. A queued event and a select-3 write in the same cycle leave the count unchanged.
- R7: The count saturates at 255. A queued event with no select-3 write at count 255 sets the exceed flag. That flag stays set until a master reset, and a select-4 write does not clear it.
- R8: A high-priority event sets the status bit equal to its code. The high-priority request and the stall are high while any status bit whose high-priority enable (select 1) is set remains uncleared. A select-5 write clears exactly the status bits written as 1.
- R9: A write to select 6 (master reset) clears the pending count and the exceed flag.
- R10: A write to select 4 sets the pending count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe |
| evt_code_i | input | EVT_W | Event code |
| evt_ptr_i | input | DATA_W | Pointer to the block that raised the event |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | DATA_W | Host write data |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | DATA_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| qptr_o | output | DATA_W | Address of the next packet slot |
| pend_cnt_o | output | CNT_W | Count of unserviced standard packets |
| exceed_o | output | 1 | Sticky overflow flag |
| hp_status_o | output | N_EVT | High-priority event flags |
| std_irq_o | output | 1 | Standard interrupt request |
| hp_irq_o | output | 1 | High-priority interrupt request |
| stall_o | output | 1 | Halt request to the message engine |

## Verification
The bench drives the count into saturation and then sends the 256th event. A design that wraps the count to zero, or that fails to latch the exceed flag, is caught there. The same run of 256 packets checks that the ring pointer lands back on the start address, which catches an off-by-one in the ring length or in the pointer step. It also checks a simultaneous event and decrement, which a design that gives one side priority would get wrong. A later check confirms that the count clear leaves the exceed flag set while the master reset clears it. For the high-priority flags, the bench clears them one at a time and confirms that the stall holds until the last flag is cleared and that a flagged event writes nothing to the queue.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;
  typedef enum logic [2:0] {
    SEL_STD_EN  = 3'd0,
    SEL_HP_EN   = 3'd1,
    SEL_QBASE   = 3'd2,
    SEL_CNT_DEC = 3'd3,
    SEL_CNT_CLR = 3'd4,
    SEL_HP_W1C  = 3'd5,
    SEL_MRST    = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_CODE = 2'd1,
    WR_PTR  = 2'd2
  } wr_phase_e;

  localparam int unsigned PKT_WORDS = 2;
endpackage

// File: rtl/irq_evt_classify.sv
module irq_evt_classify #(
  parameter int unsigned N_EVT = 8,
  localparam int unsigned EVT_W = $clog2(N_EVT)
) (
  input  logic             evt_valid_i,
  input  logic [EVT_W-1:0] evt_code_i,
  input  logic [N_EVT:0]   std_en_i,
  input  logic [N_EVT-1:0] hp_en_i,
  output logic             q_push_o,
  output logic [N_EVT-1:0] hp_set_o
);
  logic [N_EVT-1:0] std_hit;
  logic [N_EVT-1:0] hp_hit;

  for (genvar g = 0; g < N_EVT; g++) begin : g_dec
    assign std_hit[g]  = (evt_code_i == EVT_W'(g)) && std_en_i[g+1];
    assign hp_hit[g]   = (evt_code_i == EVT_W'(g)) && hp_en_i[g];
    assign hp_set_o[g] = evt_valid_i && hp_hit[g];
  end

  // high priority takes the event away from the queue
  assign q_push_o = evt_valid_i && std_en_i[0] && (|std_hit) && !(|hp_hit);
endmodule

// File: rtl/irq_pend_counter.sv
module irq_pend_counter #(
  parameter int unsigned CNT_W = 8,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             dec_i,
  input  logic             clr_i,
  input  logic             mrst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             exceed_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exc_q <= 1'b0;
    end else if (mrst_i) begin
      cnt_q <= '0;
      exc_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      unique case ({push_i, dec_i})
        2'b10: begin
          if (cnt_q == CNT_MAX) exc_q <= 1'b1;
          else                  cnt_q <= cnt_q + 1'b1;
        end
        2'b01: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign exceed_o = exc_q;
endmodule

// File: rtl/irq_pkt_writer.sv
module irq_pkt_writer
  import irq_q_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned EVT_W  = 3,
  parameter int unsigned QDEPTH = 256,
  localparam int unsigned IDX_W = $clog2(QDEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [EVT_W-1:0]  code_i,
  input  logic [DATA_W-1:0] ptr_i,
  input  logic              base_load_i,
  input  logic [DATA_W-1:0] base_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] qptr_o
);
  wr_phase_e         phase_q;
  logic [EVT_W-1:0]  code_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] slot_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= WR_IDLE;
      code_q  <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (phase_q)
        WR_IDLE: if (push_i) begin
          phase_q <= WR_CODE;
          code_q  <= code_i;
          ptr_q   <= ptr_i;
        end
        WR_CODE: phase_q <= WR_PTR;
        WR_PTR:  phase_q <= WR_IDLE;
        default: phase_q <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (base_load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (phase_q == WR_PTR) begin
      idx_q <= (idx_q == IDX_W'(QDEPTH - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign slot_off    = DATA_W'(idx_q) * DATA_W'(PKT_WORDS);
  assign qptr_o      = base_q + slot_off;
  assign mem_we_o    = (phase_q != WR_IDLE);
  assign mem_addr_o  = qptr_o + DATA_W'(phase_q == WR_PTR);
  assign mem_wdata_o = (phase_q == WR_PTR) ? ptr_q : DATA_W'(code_q);
endmodule

// File: rtl/irq_hp_flags.sv
module irq_hp_flags #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] set_i,
  input  logic             w1c_i,
  input  logic [N_EVT-1:0] w1c_mask_i,
  input  logic [N_EVT-1:0] en_i,
  output logic [N_EVT-1:0] status_o,
  output logic             active_o
);
  logic [N_EVT-1:0] status_q;
  logic [N_EVT-1:0] clr_mask;

  assign clr_mask = w1c_i ? w1c_mask_i : '0;

  // a new event wins over a clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_mask) | set_i;
  end

  assign status_o = status_q;
  assign active_o = |(status_q & en_i);
endmodule

// File: rtl/irq_event_queue.sv
module irq_event_queue
  import irq_q_pkg::*;
#(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned QDEPTH = 256,
  localparam int unsigned EVT_W = $clog2(N_EVT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [EVT_W-1:0]  evt_code_i,
  input  logic [DATA_W-1:0] evt_ptr_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] qptr_o,
  output logic [CNT_W-1:0]  pend_cnt_o,
  output logic              exceed_o,
  output logic [N_EVT-1:0]  hp_status_o,
  output logic              std_irq_o,
  output logic              hp_irq_o,
  output logic              stall_o
);
  logic [N_EVT:0]   std_en_q;
  logic [N_EVT-1:0] hp_en_q;
  logic             q_push;
  logic [N_EVT-1:0] hp_set;
  logic             cnt_dec, cnt_clr, cnt_mrst, qbase_load, hp_w1c;
  logic             hp_active;

  assign cnt_dec    = reg_wr_i && (reg_sel_i == SEL_CNT_DEC);
  assign cnt_clr    = reg_wr_i && (reg_sel_i == SEL_CNT_CLR);
  assign cnt_mrst   = reg_wr_i && (reg_sel_i == SEL_MRST);
  assign qbase_load = reg_wr_i && (reg_sel_i == SEL_QBASE);
  assign hp_w1c     = reg_wr_i && (reg_sel_i == SEL_HP_W1C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      std_en_q <= '0;
      hp_en_q  <= '0;
    end else if (reg_wr_i) begin
      if (reg_sel_i == SEL_STD_EN) std_en_q <= reg_wdata_i[N_EVT:0];
      if (reg_sel_i == SEL_HP_EN)  hp_en_q  <= reg_wdata_i[N_EVT-1:0];
    end
  end

  irq_evt_classify #(.N_EVT(N_EVT)) i_classify (
    .evt_valid_i (evt_valid_i),
    .evt_code_i  (evt_code_i),
    .std_en_i    (std_en_q),
    .hp_en_i     (hp_en_q),
    .q_push_o    (q_push),
    .hp_set_o    (hp_set)
  );

  irq_pend_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (q_push),
    .dec_i    (cnt_dec),
    .clr_i    (cnt_clr),
    .mrst_i   (cnt_mrst),
    .cnt_o    (pend_cnt_o),
    .exceed_o (exceed_o)
  );

  irq_pkt_writer #(
    .DATA_W (DATA_W),
    .EVT_W  (EVT_W),
    .QDEPTH (QDEPTH)
  ) i_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (q_push),
    .code_i      (evt_code_i),
    .ptr_i       (evt_ptr_i),
    .base_load_i (qbase_load),
    .base_i      (reg_wdata_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .qptr_o      (qptr_o)
  );

  irq_hp_flags #(.N_EVT(N_EVT)) i_hp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hp_set),
    .w1c_i      (hp_w1c),
    .w1c_mask_i (reg_wdata_i[N_EVT-1:0]),
    .en_i       (hp_en_q),
    .status_o   (hp_status_o),
    .active_o   (hp_active)
  );

  assign std_irq_o = (pend_cnt_o != '0);
  assign hp_irq_o  = hp_active;
  assign stall_o   = hp_active;
endmodule

// File: rtl/irq_q_checker.sv
module irq_q_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned EVT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic [EVT_W-1:0]  evt_code_i,
  input logic              reg_wr_i,
  input logic              q_push,
  input logic              cnt_dec,
  input logic              cnt_clr,
  input logic              cnt_mrst,
  input logic              qbase_load,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] qptr_o,
  input logic [CNT_W-1:0]  pend_cnt_o,
  input logic              exceed_o,
  input logic              stall_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_code_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && !mem_we_o) |=> (mem_we_o && mem_addr_o == $past(qptr_o)
                               && mem_wdata_o == DATA_W'($past(evt_code_i))));

  assert_ptr_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_qptr_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_we_o) && !$past(qbase_load)) |-> (qptr_o != $past(qptr_o)));

  assert_cnt_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && !cnt_dec && !cnt_clr && !cnt_mrst && pend_cnt_o != CMAX)
      |=> (pend_cnt_o == $past(pend_cnt_o) + 1'b1));

  assert_cnt_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_push && cnt_dec && !cnt_clr && !cnt_mrst && pend_cnt_o != '0)
      |=> (pend_cnt_o == $past(pend_cnt_o) - 1'b1));

  assert_cnt_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && cnt_dec && !cnt_clr && !cnt_mrst) |=> $stable(pend_cnt_o));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && !cnt_dec && !cnt_clr && !cnt_mrst && pend_cnt_o == CMAX)
      |=> (pend_cnt_o == CMAX && exceed_o));

  assert_exceed_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exceed_o && !cnt_mrst) |=> exceed_o);

  assert_stall_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> ($past(evt_valid_i) || $past(reg_wr_i)));

  assert_mrst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_mrst |=> (pend_cnt_o == '0 && !exceed_o));

  assert_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> (pend_cnt_o == '0));
endmodule

bind irq_event_queue irq_q_checker #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .EVT_W  (EVT_W)
) i_irq_q_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_code_i  (evt_code_i),
  .reg_wr_i    (reg_wr_i),
  .q_push      (q_push),
  .cnt_dec     (cnt_dec),
  .cnt_clr     (cnt_clr),
  .cnt_mrst    (cnt_mrst),
  .qbase_load  (qbase_load),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .qptr_o      (qptr_o),
  .pend_cnt_o  (pend_cnt_o),
  .exceed_o    (exceed_o),
  .stall_o     (stall_o)
);

// File: tb/test_irq_event_queue.sv
module test_irq_event_queue;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        is_wr;
    logic [2:0]  sel;
    logic [15:0] dat;
    logic [2:0]  code;
    logic [7:0]  exp_cnt;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 14;
  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 3'd0, 16'h0007, 3'd0, 8'd0, 4'd2},  // R2 master + codes 0,1
    '{1'b0, 3'd0, 16'h0100, 3'd0, 8'd1, 4'd5},  // R5
    '{1'b0, 3'd0, 16'h0110, 3'd1, 8'd2, 4'd5},  // R5
    '{1'b0, 3'd0, 16'h0120, 3'd2, 8'd2, 4'd2},  // R2 code not enabled
    '{1'b1, 3'd3, 16'h0000, 3'd0, 8'd1, 4'd6},  // R6 decrement
    '{1'b1, 3'd0, 16'h0006, 3'd0, 8'd1, 4'd2},  // R2 master off
    '{1'b0, 3'd0, 16'h0130, 3'd0, 8'd1, 4'd2},  // R2 ignored
    '{1'b1, 3'd0, 16'h01FF, 3'd0, 8'd1, 4'd2},  // R2 all on
    '{1'b0, 3'd0, 16'h0140, 3'd7, 8'd2, 4'd5},  // R5 top code
    '{1'b1, 3'd3, 16'h0000, 3'd0, 8'd1, 4'd6},  // R6
    '{1'b1, 3'd3, 16'h0000, 3'd0, 8'd0, 4'd6},  // R6
    '{1'b1, 3'd3, 16'h0000, 3'd0, 8'd0, 4'd6},  // R6 floor at 0
    '{1'b0, 3'd0, 16'h0150, 3'd3, 8'd1, 4'd5},  // R5
    '{1'b1, 3'd4, 16'h0000, 3'd0, 8'd0, 4'd10}  // R10 clear
  };

  logic        clk;
  logic        rst_ni;
  logic        evt_valid_i;
  logic [2:0]  evt_code_i;
  logic [15:0] evt_ptr_i;
  logic        reg_wr_i;
  logic [2:0]  reg_sel_i;
  logic [15:0] reg_wdata_i;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] qptr_o;
  logic [7:0]  pend_cnt_o;
  logic        exceed_o;
  logic [7:0]  hp_status_o;
  logic        std_irq_o;
  logic        hp_irq_o;
  logic        stall_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  irq_event_queue i_irq_event_queue (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_code_i(evt_code_i), .evt_ptr_i(evt_ptr_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .qptr_o(qptr_o), .pend_cnt_o(pend_cnt_o), .exceed_o(exceed_o),
    .hp_status_o(hp_status_o), .std_irq_o(std_irq_o), .hp_irq_o(hp_irq_o),
    .stall_o(stall_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_evt(input logic [2:0] code, input logic [15:0] ptr, input logic with_dec);
    @(negedge clk);
    evt_valid_i = 1'b1; evt_code_i = code; evt_ptr_i = ptr;
    if (with_dec) begin reg_wr_i = 1'b1; reg_sel_i = 3'd3; end
    @(negedge clk);
    evt_valid_i = 1'b0; reg_wr_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [15:0] dat);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = dat;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; evt_valid_i = 1'b0; evt_code_i = '0; evt_ptr_i = '0;
    reg_wr_i = 1'b0; reg_sel_i = '0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "count", pend_cnt_o, 0);
    chk(1, "exceed", exceed_o, 0);
    chk(1, "std irq", std_irq_o, 0);
    chk(1, "hp irq", hp_irq_o, 0);
    chk(1, "stall", stall_o, 0);
    chk(1, "mem we", mem_we_o, 0);
    chk(1, "qptr", qptr_o, 0);

    for (int i = 0; i < N_VEC; i++) begin
      if (VECS[i].is_wr) reg_write(VECS[i].sel, VECS[i].dat);
      else               send_evt(VECS[i].code, VECS[i].dat, 1'b0);
      chk(int'(VECS[i].req), "vector count", pend_cnt_o, VECS[i].exp_cnt);
      chk(5, "vector std irq", std_irq_o, VECS[i].exp_cnt != 0);
    end

    // R2 ignored event writes nothing
    reg_write(3'd0, 16'h01FD);
    begin
      logic [15:0] q0;
      q0 = qptr_o;
      @(negedge clk); evt_valid_i = 1'b1; evt_code_i = 3'd0; evt_ptr_i = 16'h0DEF;
      @(negedge clk); evt_valid_i = 1'b0;
      chk(2, "ignored mem we", mem_we_o, 0);
      @(negedge clk);
      chk(2, "ignored qptr", qptr_o, q0);
      chk(2, "ignored count", pend_cnt_o, 0);
    end
    reg_write(3'd0, 16'h01FF);

    // R3/R4 packet layout
    reg_write(3'd2, 16'h1000);
    chk(4, "qptr load", qptr_o, 16'h1000);
    @(negedge clk); evt_valid_i = 1'b1; evt_code_i = 3'd5; evt_ptr_i = 16'hBEEF;
    @(negedge clk); evt_valid_i = 1'b0;
    chk(3, "word0 we", mem_we_o, 1);
    chk(3, "word0 addr", mem_addr_o, 16'h1000);
    chk(3, "word0 data", mem_wdata_o, 16'h0005);
    @(negedge clk);
    chk(3, "word1 we", mem_we_o, 1);
    chk(3, "word1 addr", mem_addr_o, 16'h1001);
    chk(3, "word1 data", mem_wdata_o, 16'hBEEF);
    @(negedge clk);
    chk(3, "idle after packet", mem_we_o, 0);
    chk(4, "qptr step", qptr_o, 16'h1002);
    chk(5, "count after packet", pend_cnt_o, 1);

    // R7 saturation, R4 wrap
    for (int i = 0; i < 254; i++) send_evt(3'(i), 16'(i), 1'b0);
    chk(7, "count at 255", pend_cnt_o, 255);
    chk(7, "exceed before", exceed_o, 0);
    chk(4, "qptr after 255", qptr_o, 16'h11FE);
    send_evt(3'd6, 16'h2222, 1'b0);
    chk(7, "count saturated", pend_cnt_o, 255);
    chk(7, "exceed set", exceed_o, 1);
    chk(4, "qptr wrapped", qptr_o, 16'h1000);
    send_evt(3'd1, 16'h3333, 1'b1);
    chk(6, "push+dec at 255", pend_cnt_o, 255);
    reg_write(3'd4, 16'h0000);
    chk(10, "clear count", pend_cnt_o, 0);
    chk(7, "exceed survives clear", exceed_o, 1);
    send_evt(3'd2, 16'h4444, 1'b0);
    chk(5, "count after clear", pend_cnt_o, 1);
    reg_write(3'd6, 16'h0000);
    chk(9, "mrst count", pend_cnt_o, 0);
    chk(9, "mrst exceed", exceed_o, 0);
    send_evt(3'd0, 16'h5555, 1'b0);
    send_evt(3'd4, 16'h6666, 1'b1);
    chk(6, "push+dec at 1", pend_cnt_o, 1);

    // R8 high-priority flags
    reg_write(3'd1, 16'h000C);
    @(negedge clk); evt_valid_i = 1'b1; evt_code_i = 3'd2; evt_ptr_i = 16'h7777;
    @(negedge clk); evt_valid_i = 1'b0;
    chk(8, "hp no write", mem_we_o, 0);
    chk(8, "hp status", hp_status_o, 8'h04);
    chk(8, "hp stall", stall_o, 1);
    chk(8, "hp irq", hp_irq_o, 1);
    chk(2, "hp not queued", pend_cnt_o, 1);
    send_evt(3'd3, 16'h8888, 1'b0);
    chk(8, "hp two flags", hp_status_o, 8'h0C);
    reg_write(3'd5, 16'h0004);
    chk(8, "w1c one bit", hp_status_o, 8'h08);
    chk(8, "stall holds", stall_o, 1);
    reg_write(3'd5, 16'h0008);
    chk(8, "w1c last bit", hp_status_o, 8'h00);
    chk(8, "stall released", stall_o, 0);
    chk(8, "hp irq released", hp_irq_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule